// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs one management transaction at a time towards an external PHY over the two-wire MDC/MDIO interface. Software writes a 32-bit control word that carries the PHY address, the register address within that PHY, a direction flag, a 4-bit clock-range code and a busy flag. A separate 16-bit data word holds the value to send, or receives the value read back. Writing the control word with the busy flag at 1 starts a transaction. The block then derives MDC from the system clock and shifts out a clause-22 frame. On a read it releases MDIO and samples the PHY's reply. When the frame ends it clears the busy flag.

MDIO is split into an output, an output enable and an input so that a pad or a bench can resolve the shared line. The PHY never acknowledges a transaction. The busy flag therefore clears after a fixed number of MDC periods whether or not a PHY is connected. With no PHY present, a read returns whatever the pulled-up idle line gave, which is all ones.

Top module: `mdio_master`

## Requirements
- R1: The control word places the PHY address in bits 15:11, the register address in bits 10:6, the range code in bits 5:2, the write flag in bit 1 and busy in bit 0. Bits 31:16 always read as zero. Writing it with bit 0 at 0 starts nothing.
- R2: For range codes with bit 3 clear, the MDC divisor is 42, 62, 16, 26, 102 or 124 for codes 0 to 5. The reserved codes 6 and 7 use 124. MDC is high for half the divisor and low for half, counted in system clocks.
- R3: For range codes with bit 3 set, the divisor is 4 + 2*(code bits 2:0), which gives 4 up to 18.
- R4: Busy reads 1 from the clock edge that takes the start write. It clears exactly 64*divisor+1 system clocks after that edge, with no acknowledgement needed from the PHY.
- R5: A write frame has 64 bits, most significant first. The bits are 32 ones, start 01, opcode 01, the 5-bit PHY address, the 5-bit register address, turnaround 10 and then the 16 data bits. MDIO output changes only on MDC falling edges.
- R6: A read frame sends opcode 10 and keeps the output enable high for the first 46 bits only. The enable stays low for the turnaround and the 16 data bits. The data bits are sampled on MDC rising edges, most significant first, and are placed in the data word when busy clears.
- R7: A read with no PHY driving the line returns 0xFFFF in the data word.
- R8: Between transactions MDC is low and the output enable is low.
- R9: While busy is 1, writes to the control word or the data word are ignored. The divisor, fields and data stay as they were when the transaction started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 is the control word, 1 is the data word |
| reg_wdata | input | 32 | Write data |
| ctrl_word | output | 32 | Current control word |
| data_word | output | 32 | Current data word, upper 16 bits zero |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen on the line |

## Verification
The bench goes after the divisor table code by code, including the reserved codes and every fast code. A swapped or off-by-one table entry shows up as a wrong MDC high width and a wrong busy duration. It decodes every driven bit of each frame, so a missing preamble bit, a wrong opcode or a reversed address field appears as a frame mismatch. On reads, the bench PHY answers only after the 46th bit. A design that keeps driving through the turnaround, or that samples on the wrong edge, flags an enable violation or returns shifted data. The bench also writes new fields and data in mid-transaction and starts a read with no PHY. A design that accepts writes while busy, or that waits for an acknowledgement, then corrupts the frame or hangs busy.

// File: rtl/mdio_pkg.sv
// Package: constants of the clause-22 management frame and the
// range-code to half-period mapping. Assumes the fixed 64-bit frame.
package mdio_pkg;
    localparam int PHY_AW    = 5;
    localparam int REG_AW    = 5;
    localparam int DATA_W    = 16;
    localparam int PRE_LEN   = 32;
    localparam int TA_LEN    = 2;
    localparam int FRAME_LEN = PRE_LEN + 4 + PHY_AW + REG_AW + TA_LEN + DATA_W;
    localparam int RD_DRIVE  = FRAME_LEN - DATA_W - TA_LEN;
    localparam int CNT_W     = $clog2(FRAME_LEN);
    localparam int HALF_W    = 6;
    localparam int CODE_W    = 4;

    // Half of the MDC divisor for a range code; reserved codes fall back to the slowest.
    function automatic logic [HALF_W-1:0] half_period(input logic [CODE_W-1:0] code);
        logic [HALF_W-1:0] h;
        if (code[3]) begin
            h = {3'b000, code[2:0]} + 6'd2;
        end else begin
            case (code[2:0])
                3'd0:    h = 6'd21;
                3'd1:    h = 6'd31;
                3'd2:    h = 6'd8;
                3'd3:    h = 6'd13;
                3'd4:    h = 6'd51;
                default: h = 6'd62;
            endcase
        end
        return h;
    endfunction
endpackage

// File: rtl/mdio_clkgen.sv
// Module: MDC generator. Toggles MDC every HALF system clocks while run is
// high and reports the rising and falling toggles as one-cycle events.
// Assumes half >= 2 and stable while run is high; MDC idles low.
module mdio_clkgen #(
    parameter int HALF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              mdc,
    output logic              rise_evt,
    output logic              fall_evt
);
    logic [HALF_W-1:0] cnt;
    logic              tick;

    // Terminal count of the current half period.
    assign tick     = run && (cnt == half - {{(HALF_W-1){1'b0}}, 1'b1});
    assign rise_evt = tick && !mdc;
    assign fall_evt = tick && mdc;

    // Half-period counter and MDC toggle, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (tick) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + {{(HALF_W-1){1'b0}}, 1'b1};
        end
    end

    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);

    a_r2_half_period: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc != $past(mdc)) |-> ($past(cnt) == $past(half) - 1));
endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. On start it latches the divisor and builds the
// 64-bit frame, shifts one bit per MDC period on falling edges, releases
// MDIO for the read turnaround and data, samples read data on rising
// edges, and pulses done on the last falling edge. Assumes start only
// arrives while idle.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr,
    input  logic [PHY_AW-1:0] pa,
    input  logic [REG_AW-1:0] ra,
    input  logic [CODE_W-1:0] code,
    input  logic [DATA_W-1:0] wdata,
    input  logic              mdio_in,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              active,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(FRAME_LEN - 1);
    localparam logic [CNT_W-1:0] DRV_LIMIT = CNT_W'(RD_DRIVE);
    localparam logic [CNT_W-1:0] DATA_BIT0 = CNT_W'(FRAME_LEN - DATA_W);

    logic [FRAME_LEN-1:0] sr;
    logic [FRAME_LEN-1:0] frame;
    logic [CNT_W-1:0]     bitcnt;
    logic                 wr_q;
    logic [HALF_W-1:0]    half_q;
    logic                 rise_evt;
    logic                 fall_evt;

    mdio_clkgen #(.HALF_W(HALF_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .half     (half_q),
        .mdc      (mdc),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    // Frame image: preamble, start, opcode, addresses, then turnaround and data or idle ones.
    assign frame = {{PRE_LEN{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), pa, ra,
                    (wr ? {2'b10, wdata} : {(DATA_W+TA_LEN){1'b1}})};

    assign done     = active && fall_evt && (bitcnt == LAST_BIT);
    assign mdio_out = active ? sr[FRAME_LEN-1] : 1'b1;
    assign mdio_oe  = active && (wr_q || (bitcnt < DRV_LIMIT));

    // Transaction state: load on start, advance one bit per MDC falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            sr     <= '1;
            bitcnt <= '0;
            wr_q   <= 1'b0;
            half_q <= HALF_W'(2);
        end else if (start) begin
            active <= 1'b1;
            sr     <= frame;
            bitcnt <= '0;
            wr_q   <= wr;
            half_q <= half_period(code);
        end else if (active && fall_evt) begin
            sr     <= {sr[FRAME_LEN-2:0], 1'b1};
            bitcnt <= bitcnt + {{(CNT_W-1){1'b0}}, 1'b1};
            if (bitcnt == LAST_BIT) active <= 1'b0;
        end
    end

    // Read data capture on MDC rising edges during the data bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (active && rise_evt && !wr_q && (bitcnt >= DATA_BIT0)) begin
            rdata <= {rdata[DATA_W-2:0], mdio_in};
        end
    end

    a_r5_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(active) && (mdio_out != $past(mdio_out))) |-> $past(fall_evt));

    a_r6_no_drive_read: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !wr_q && (bitcnt >= DRV_LIMIT)) |-> !mdio_oe);
endmodule

// File: rtl/mdio_regs.sv
// Module: register interface. Holds the control and data words, accepts
// writes only while idle, issues a start pulse when busy is written as 1,
// and on done clears busy and stores read data. Assumes done only while busy.
module mdio_regs
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [31:0]       reg_wdata,
    input  logic              done,
    input  logic [DATA_W-1:0] rdata,
    output logic [31:0]       ctrl_word,
    output logic [31:0]       data_word,
    output logic              start,
    output logic              busy,
    output logic              wr,
    output logic [PHY_AW-1:0] pa,
    output logic [REG_AW-1:0] ra,
    output logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data_q
);
    logic accept;

    // Writes are taken only when no transaction is running.
    assign accept    = reg_wr && !busy;
    assign ctrl_word = {16'h0000, pa, ra, code, wr, busy};
    assign data_word = {16'h0000, data_q};

    // Register updates: software writes while idle, completion from the sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            wr     <= 1'b0;
            pa     <= '0;
            ra     <= '0;
            code   <= '0;
            data_q <= '0;
            start  <= 1'b0;
        end else begin
            start <= accept && !reg_sel && reg_wdata[0];
            if (done) begin
                busy <= 1'b0;
                if (!wr) data_q <= rdata;
            end
            if (accept && !reg_sel) begin
                pa   <= reg_wdata[15:11];
                ra   <= reg_wdata[10:6];
                code <= reg_wdata[5:2];
                wr   <= reg_wdata[1];
                busy <= reg_wdata[0];
            end
            if (accept && reg_sel) data_q <= reg_wdata[DATA_W-1:0];
        end
    end

    a_r9_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pa) && $stable(ra) && $stable(code)
                                   && $stable(wr) && $stable(data_q)));

    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/mdio_master.sv
// Module: top of the station-management master. Ties the register
// interface to the frame sequencer. Assumes mdio_in reflects the shared
// line (pulled up when undriven).
module mdio_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] ctrl_word,
    output logic [31:0] data_word,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    input  logic        mdio_in
);
    logic              start;
    logic              busy;
    logic              wr;
    logic [PHY_AW-1:0] pa;
    logic [REG_AW-1:0] ra;
    logic [CODE_W-1:0] code;
    logic [DATA_W-1:0] data_q;
    logic              done;
    logic              active;
    logic [DATA_W-1:0] rdata;

    mdio_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .done      (done),
        .rdata     (rdata),
        .ctrl_word (ctrl_word),
        .data_word (data_word),
        .start     (start),
        .busy      (busy),
        .wr        (wr),
        .pa        (pa),
        .ra        (ra),
        .code      (code),
        .data_q    (data_q)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wr       (wr),
        .pa       (pa),
        .ra       (ra),
        .code     (code),
        .wdata    (data_q),
        .mdio_in  (mdio_in),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .active   (active),
        .done     (done),
        .rdata    (rdata)
    );

    a_r4_active_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> busy);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |-> (!mdio_oe && !mdc));
endmodule

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_word;
    logic [31:0] data_word;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // PHY model state
    int          rise_cnt = 0;
    int          oe_viol = 0;
    logic [63:0] cap = '0;
    logic        phy_on = 1'b0;
    logic [15:0] phy_val = '0;

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_word(ctrl_word), .data_word(data_word),
        .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY model: records driven bits on MDC rise, answers reads after MDC fall.
    always @(posedge mdc) begin
        cap = {cap[62:0], mdio_out};
        if (rise_cnt >= 46 && mdio_oe && !ctrl_word[1]) oe_viol++;
        rise_cnt++;
    end
    always @(negedge mdc) begin
        if (phy_on && rise_cnt >= 48 && rise_cnt <= 63)
            mdio_in = phy_val[15 - (rise_cnt - 48)];
        else
            mdio_in = 1'b1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int exp_div(input logic [3:0] code);
        if (code[3]) return 4 + 2 * int'(code[2:0]);
        case (code[2:0])
            3'd0: return 42;
            3'd1: return 62;
            3'd2: return 16;
            3'd3: return 26;
            3'd4: return 102;
            default: return 124;
        endcase
    endfunction

    task automatic reg_write(input logic sel, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic phy_clear();
        rise_cnt = 0; oe_viol = 0; cap = '0;
    endtask

    // Starts a transaction and returns busy duration and MDC high width.
    task automatic run_txn(input logic [4:0] pa, input logic [4:0] ra,
                           input logic [3:0] code, input logic w,
                           output int dur, output int hw);
        int c0;
        int guard;
        phy_clear();
        reg_write(1'b0, {16'h0, pa, ra, code, w, 1'b1});
        c0 = cyc;
        hw = 0;
        guard = 0;
        while (!mdc && guard < 200) begin @(negedge clk); guard++; end
        while (mdc && hw < 200) begin @(negedge clk); hw++; end
        guard = 0;
        while (ctrl_word[0] && guard < 20000) begin @(negedge clk); guard++; end
        dur = cyc - c0;
    endtask

    task automatic t_reset();
        check(ctrl_word == 32'h0, "R1", "reset ctrl", ctrl_word, 0);
        check(data_word == 32'h0, "R1", "reset data", data_word, 0);
        check(!mdc && !mdio_oe, "R8", "reset mdc/oe", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_fields();
        reg_write(1'b0, 32'hABCD_FFFE);
        check(ctrl_word == 32'h0000_FFFE, "R1", "upper zero, fields", ctrl_word, 32'h0000_FFFE);
        repeat (10) @(negedge clk);
        check(!mdc && !mdio_oe && !ctrl_word[0], "R1", "no start without busy",
              {mdc, mdio_oe, ctrl_word[0]}, 0);
        reg_write(1'b0, 32'h0);
    endtask

    task automatic t_write(input logic [4:0] pa, input logic [4:0] ra,
                           input logic [3:0] code, input logic [15:0] d, input string req);
        int dur, hw, n;
        logic [63:0] exp;
        n = exp_div(code);
        reg_write(1'b1, {16'h0, d});
        run_txn(pa, ra, code, 1'b1, dur, hw);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b01, pa, ra, 2'b10, d};
        check(hw == n / 2, req, "mdc high width", hw, n / 2);
        check(dur == 64 * n + 1, "R4", "busy duration", dur, 64 * n + 1);
        check(cap == exp && rise_cnt == 64, "R5", "write frame", cap, exp);
        check(!mdc && !mdio_oe, "R8", "idle after write", {mdc, mdio_oe}, 0);
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra,
                          input logic [3:0] code, input logic on, input logic [15:0] v);
        int dur, hw, n;
        logic [45:0] exp;
        n = exp_div(code);
        phy_on = on; phy_val = v;
        run_txn(pa, ra, code, 1'b0, dur, hw);
        exp = {32'hFFFF_FFFF, 2'b01, 2'b10, pa, ra};
        check(cap[63:18] == exp, "R6", "read header", cap[63:18], exp);
        check(oe_viol == 0, "R6", "released after bit 46", oe_viol, 0);
        check(dur == 64 * n + 1, "R4", "read busy duration", dur, 64 * n + 1);
        if (on)
            check(data_word == {16'h0, v}, "R6", "read data", data_word, v);
        else
            check(data_word == 32'h0000_FFFF, "R7", "no PHY read", data_word, 32'hFFFF);
        phy_on = 1'b0;
    endtask

    task automatic t_ignore();
        int guard;
        logic [63:0] exp;
        phy_clear();
        reg_write(1'b1, 32'h0000_5A3C);
        reg_write(1'b0, {16'h0, 5'd9, 5'd22, 4'b1000, 1'b1, 1'b1});
        repeat (20) @(negedge clk);
        reg_write(1'b0, {16'h0, 5'd31, 5'd1, 4'b0101, 1'b0, 1'b1});
        reg_write(1'b1, 32'h0000_FFFF);
        check(ctrl_word[15:1] == {5'd9, 5'd22, 4'b1000, 1'b1}, "R9", "ctrl kept while busy",
              ctrl_word[15:1], {5'd9, 5'd22, 4'b1000, 1'b1});
        guard = 0;
        while (ctrl_word[0] && guard < 20000) begin @(negedge clk); guard++; end
        exp = {32'hFFFF_FFFF, 4'b0101, 5'd9, 5'd22, 2'b10, 16'h5A3C};
        check(cap == exp, "R9", "frame unaffected", cap, exp);
        check(data_word == 32'h0000_5A3C, "R9", "data kept", data_word, 32'h5A3C);
        repeat (40) @(negedge clk);
        check(!mdc && rise_cnt == 64, "R9", "no second frame", rise_cnt, 64);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fields();
        t_write(5'd1, 5'd2, 4'b0000, 16'hA5C3, "R2");
        t_write(5'd17, 5'd30, 4'b0001, 16'h0001, "R2");
        t_write(5'd3, 5'd4, 4'b0010, 16'h8000, "R2");
        t_write(5'd5, 5'd6, 4'b0011, 16'h1234, "R2");
        t_write(5'd7, 5'd8, 4'b0100, 16'hFFFF, "R2");
        t_write(5'd9, 5'd10, 4'b0101, 16'h0000, "R2");
        t_write(5'd11, 5'd12, 4'b0110, 16'hBEEF, "R2");
        t_write(5'd13, 5'd14, 4'b0111, 16'h7E81, "R2");
        for (int k = 8; k < 16; k++)
            t_write(5'(k), 5'(31 - k), 4'(k), 16'(k * 16'h1111), "R3");
        t_read(5'd21, 5'd3, 4'b1010, 1'b1, 16'hC3A5);
        t_read(5'd0, 5'd31, 4'b0010, 1'b1, 16'h0001);
        t_read(5'd31, 5'd0, 4'b1111, 1'b0, 16'h0000);
        t_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule